// File: doc/BRIEF.md
# Write-Once System Options Register

This block is a one-byte system configuration register that sits on a simple byte-wide peripheral bus. It holds five live controls: watchdog enable, watchdog timeout length, low-power stop permission, debug-pin function select and reset-pin function select. It also holds one reserved bit that is stored but drives nothing. After any reset, the register accepts exactly one write. It then locks and ignores all further writes until the next reset. Reads see the current contents at all times.

Two reset inputs are provided, and they clear different things:

- The general reset clears the lock and returns most bits to their defaults.
- The power-on reset does everything the general reset does and also clears the reset-pin select bit. A warm reset leaves that bit unchanged.

The block also filters a stop-request strobe from the core:

- If stop is permitted, the strobe becomes a one-cycle stop-entry pulse.
- If stop is not permitted, the strobe becomes a one-cycle illegal-opcode reset request.

Top module: `sysopt_wo_reg`

## Requirements
- R1: After power-on reset (`por_ni` low), `rdata_o` reads 0xD2: bits 7, 6, 4 and 1 are 1, and bits 5, 3, 2 and 0 are 0.
- R2: The first write after any reset (`we_i` high at a rising clock edge) updates the register, and `rdata_o` shows the written value, with bits 3 and 2 forced to 0, from that edge on.
- R3: Once one write has been accepted, every later write leaves `rdata_o` unchanged until the next reset.
- R4: A warm reset (`rst_ni` low, `por_ni` high) returns bits 7..1 to the R1 values, keeps bit 0 at its value before the reset, and re-arms the register to accept one more write.
- R5: Bits 3 and 2 always read 0, whatever value is written to them.
- R6: Bit 4 is stored and read back like any other bit, but it changes no output other than `rdata_o`.
- R7: When bit 5 is 0, a cycle with `stop_req_i` high produces `illop_rst_o` high for exactly the next cycle, and `stop_entry_o` stays low.
- R8: When bit 5 is 1, a cycle with `stop_req_i` high produces `stop_entry_o` high for exactly the next cycle, and `illop_rst_o` stays low.
- R9: `wdog_en_o` equals bit 7, `wdog_long_o` equals bit 6, `dbg_pin_en_o` equals bit 1, and both `rst_pin_en_o` and `rst_pullup_o` equal bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | General asynchronous reset, active low |
| por_ni | input | 1 | Power-on asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register contents |
| stop_req_i | input | 1 | Stop request strobe from the core |
| stop_entry_o | output | 1 | One-cycle stop-mode entry pulse |
| illop_rst_o | output | 1 | One-cycle illegal-opcode reset request |
| wdog_en_o | output | 1 | Watchdog enable |
| wdog_long_o | output | 1 | Watchdog long-timeout select |
| dbg_pin_en_o | output | 1 | Debug function select for the shared pin |
| rst_pin_en_o | output | 1 | Reset function select for the shared pin |
| rst_pullup_o | output | 1 | Pull-up enable for the reset pin |

## Verification
The bench sweeps all 256 values as the first write after a warm reset. For each value it then tries to overwrite with the complement. A lock that failed to engage, or one that engaged only on the following cycle, would show the complement or drop the first value.

Each warm reset is checked for bit 0 carrying over from the previous value. A design that clears bit 0 on every reset would fail on every odd first write. A power-on reset placed mid-run confirms that bit 0 does clear on power-on.

A stop strobe is sent for every swept value. A design that gates stop with the wrong bit, or that emits both pulses, would fault on half of the sweep.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int unsigned OPT_W       = 8;
  localparam int unsigned WDOG_EN_B   = 7;
  localparam int unsigned WDOG_LONG_B = 6;
  localparam int unsigned STOP_EN_B   = 5;
  localparam int unsigned RSVD_B      = 4;
  localparam int unsigned DBG_PIN_B   = 1;
  localparam int unsigned RST_PIN_B   = 0;
  localparam logic [OPT_W-1:0] IMPL_MASK = 8'hF3;
  localparam logic [OPT_W-1:0] RST_VAL   = 8'hD2;
endpackage

// File: rtl/sysopt_lock.sv
module sysopt_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic accept_o,
  output logic locked_o
);
  logic locked_q;

  assign accept_o = wr_i & ~locked_q;
  assign locked_o = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       locked_q <= 1'b0;
    else if (accept_o) locked_q <= 1'b1;
  end

  a_r2_lock_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !locked_q) |=> locked_q);
  a_r3_lock_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
endmodule

// File: rtl/sysopt_bits.sv
module sysopt_bits #(
  parameter int unsigned W         = sysopt_pkg::OPT_W,
  parameter logic [W-1:0] IMPL     = sysopt_pkg::IMPL_MASK,
  parameter logic [W-1:0] RST_V    = sysopt_pkg::RST_VAL,
  parameter int unsigned  POR_ONLY = sysopt_pkg::RST_PIN_B
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         por_ni,
  input  logic         load_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (!IMPL[i]) begin : g_none
      assign q_o[i] = 1'b0;
    end else if (i == POR_ONLY) begin : g_por
      logic b_q;
      always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni)     b_q <= 1'b0;
        else if (load_i) b_q <= wdata_i[i];
      end
      assign q_o[i] = b_q;
    end else begin : g_any
      logic b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     b_q <= RST_V[i];
        else if (load_i) b_q <= wdata_i[i];
      end
      assign q_o[i] = b_q;
    end
  end

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    load_i |=> (q_o == ($past(wdata_i) & IMPL)));
endmodule

// File: rtl/sysopt_stop_gate.sv
module sysopt_stop_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic stop_en_i,
  output logic stop_entry_o,
  output logic illop_rst_o
);
  logic entry_q, illop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= 1'b0;
      illop_q <= 1'b0;
    end else begin
      entry_q <= stop_req_i &  stop_en_i;
      illop_q <= stop_req_i & ~stop_en_i;
    end
  end

  assign stop_entry_o = entry_q;
  assign illop_rst_o  = illop_q;

  a_r7_illop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && !stop_en_i) |=> (illop_rst_o && !stop_entry_o));
  a_r8_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && stop_en_i) |=> (stop_entry_o && !illop_rst_o));
  a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_req_i |=> !(stop_entry_o || illop_rst_o));
endmodule

// File: rtl/sysopt_wo_reg.sv
module sysopt_wo_reg
  import sysopt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       stop_req_i,
  output logic       stop_entry_o,
  output logic       illop_rst_o,
  output logic       wdog_en_o,
  output logic       wdog_long_o,
  output logic       dbg_pin_en_o,
  output logic       rst_pin_en_o,
  output logic       rst_pullup_o
);
  logic             any_rst_n;
  logic             accept, locked;
  logic [OPT_W-1:0] opt_q;

  // power-on reset also acts as a general reset
  assign any_rst_n = rst_ni & por_ni;

  sysopt_lock u_lock (
    .clk_i   (clk_i),
    .rst_ni  (any_rst_n),
    .wr_i    (we_i),
    .accept_o(accept),
    .locked_o(locked)
  );

  sysopt_bits u_bits (
    .clk_i  (clk_i),
    .rst_ni (any_rst_n),
    .por_ni (por_ni),
    .load_i (accept),
    .wdata_i(wdata_i),
    .q_o    (opt_q)
  );

  sysopt_stop_gate u_stop (
    .clk_i       (clk_i),
    .rst_ni      (any_rst_n),
    .stop_req_i  (stop_req_i),
    .stop_en_i   (opt_q[STOP_EN_B]),
    .stop_entry_o(stop_entry_o),
    .illop_rst_o (illop_rst_o)
  );

  assign rdata_o      = opt_q;
  assign wdog_en_o    = opt_q[WDOG_EN_B];
  assign wdog_long_o  = opt_q[WDOG_LONG_B];
  assign dbg_pin_en_o = opt_q[DBG_PIN_B];
  assign rst_pin_en_o = opt_q[RST_PIN_B];
  assign rst_pullup_o = opt_q[RST_PIN_B];

  a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!any_rst_n)
    locked |=> $stable(rdata_o));
  a_r7_one_pulse: assert property (@(posedge clk_i) disable iff (!any_rst_n)
    !(stop_entry_o && illop_rst_o));
endmodule

// File: tb/sysopt_wo_reg_tb_top.sv
module sysopt_wo_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, por_n = 1'b0;
  logic       we = 1'b0, stop_req = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       stop_entry, illop, wd_en, wd_long, dbg_en, rp_en, rp_pu;
  int         total = 0, bad = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  sysopt_wo_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .stop_req_i(stop_req), .stop_entry_o(stop_entry),
    .illop_rst_o(illop), .wdog_en_o(wd_en), .wdog_long_o(wd_long),
    .dbg_pin_en_o(dbg_en), .rst_pin_en_o(rp_en), .rst_pullup_o(rp_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic warm_rst();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pins(input logic [7:0] e);
    chk("R9", {3'b0, wd_en, wd_long, dbg_en, rp_en, rp_pu},
              {3'b0, e[7], e[6], e[1], e[0], e[0]});
  endtask

  task automatic stop_try(input logic [7:0] e);
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    if (e[5]) chk("R8", {6'b0, stop_entry, illop}, 8'b10);
    else      chk("R7", {6'b0, stop_entry, illop}, 8'b01);
    @(negedge clk);
    chk(e[5] ? "R8" : "R7", {6'b0, stop_entry, illop}, 8'b00);
  endtask

  initial begin
    logic [7:0] exp;
    logic       b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rdata, 8'hD2);
    pins(8'hD2);
    stop_try(8'hD2);
    b0 = 1'b0;
    for (int v = 0; v < 256; v++) begin
      if (v == 128) begin
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        chk("R1", rdata, 8'hD2);
        b0 = 1'b0;
      end else begin
        warm_rst();
        chk("R4", rdata, {7'b1101_001, b0});
      end
      wr(8'(v));
      exp = 8'(v) & 8'hF3;
      chk("R2", rdata, exp);
      chk("R5", {6'b0, rdata[3:2]}, 8'h00);
      pins(exp);
      chk("R6", {7'b0, rdata[4]}, {7'b0, exp[4]});
      wr(~8'(v));
      chk("R3", rdata, exp);
      wr(8'h5A ^ 8'(v));
      chk("R3", rdata, exp);
      pins(exp);
      stop_try(exp);
      b0 = exp[0];
    end
    // R6: toggling bit 4 alone leaves functional outputs unchanged
    warm_rst(); wr(8'hE3); pins(8'hE3);
    warm_rst(); wr(8'hF3); pins(8'hF3);
    chk("R6", rdata, 8'hF3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); total++; bad++;
        $display("FAIL watchdog act=timeout exp=done"); end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule